// File: doc/BRIEF.md
# Sticky Interrupt Status and Enable Register

This block is a 16-bit interrupt control register on a simple host bus. Seven event inputs come in from the video and FIFO logic around it: sync error, statistics ready, last code, FIFO service request, FIFO error, FIFO stop and memory error. Six of these are captured as sticky status bits. A sticky bit is set when its input changes from low to high, and it stays set until the host reads the register. The service-request bit is not latched. It shows the live level of its input, so the host can poll it.

The host sets an enable bit for each source. The single interrupt output is high whenever any status bit and its enable are both high. Reading the register returns the status bits and the enable bits together, and clears the sticky bits. Writing the register changes only the enable bits.

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset every status bit and every enable bit reads 0, and `irq_o` is low.
- R2: A read at byte offset 0x0C returns status in bits [6:0] and enables in bits [14:8], each in the same source order. Bits 7 and 15 read 0. `rdata` is 0 in any cycle with no read at 0x0C.
- R3: `evt_in` maps bit 0 to sync error, 1 to statistics ready, 2 to last code, 3 to service request, 4 to FIFO error, 5 to FIFO stop and 6 to memory error. For every source except bit 3, a low-to-high change seen at a clock edge sets that status bit from the next cycle on.
- R4: A read at 0x0C returns the current value and clears every sticky status bit that has no new rising edge in that same cycle.
- R5: An input that stays high after its bit has been cleared does not set the bit again. It must go low and then high again.
- R6: When a rising edge and a clearing read fall in the same cycle, the read returns the old value and the status bit is set afterwards.
- R7: Status bit 3 always shows the current level of `evt_in[3]`. It is never latched and is not affected by reads.
- R8: `irq_o` is the OR over all seven sources of (status bit AND enable bit). A masked source never raises it.
- R9: A write at 0x0C loads `wdata[14:8]` into the enable bits in the next cycle. Written values in the status bit positions have no effect.
- R10: Reads and writes at any offset other than 0x0C leave both the enables and the sticky bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Host byte address |
| rd_en | input | 1 | Host read strobe, one cycle per access |
| wr_en | input | 1 | Host write strobe |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, valid in the read cycle |
| evt_in | input | 7 | Event condition inputs, mapped as in R3 |
| irq_o | output | 1 | Host interrupt request |

## Verification
Each sticky source is given a single-cycle pulse and then read twice. This separates edge capture from level capture, and shows whether a read clears the bit. Inputs that stay high across a clearing read show whether the block is edge-triggered or level-triggered. A rising edge placed in the same cycle as a read settles which of the two wins. Sparse enable masks show whether the interrupt is the masked OR or a plain OR. Accesses at other offsets show whether the address decode is complete. A stretch of pseudo-random events, reads and writes is then compared every cycle against a behavioural model.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int NUM_SRC   = 7;
  localparam int DATA_W    = 16;
  localparam int EN_LSB    = 8;
  localparam int SYNC_ERR  = 0;
  localparam int STATS_RDY = 1;
  localparam int LAST_CODE = 2;
  localparam int SRV_REQ   = 3;
  localparam int FIFO_ERR  = 4;
  localparam int FIFO_STOP = 5;
  localparam int MEM_ERR   = 6;
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic clr_i,
  output logic sts_o
);
  logic cond_q;
  logic sts_q;
  logic sts_d;
  logic rise;

  always_comb begin
    rise  = cond_i & ~cond_q;
    sts_d = sts_q;
    if (rise)       sts_d = 1'b1;
    else if (clr_i) sts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      cond_q <= cond_i;
      sts_q  <= sts_d;
    end
  end

  assign sts_o = sts_q;

  // R3 / R6: a rising edge always leaves the bit set, even when a clearing read falls in the same cycle
  a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i && !cond_q) |=> sts_o);
  // R4: a read with no new edge clears the bit
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(cond_i && !cond_q)) |=> !sts_o);
  // R5: a clear bit sets only through a rising edge
  a_r5_no_level_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_o && !(cond_i && !cond_q)) |=> !sts_o);
endmodule

// File: rtl/irq_host_port.sv
module irq_host_port #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h0C,
  parameter int N      = 7,
  parameter int DATA_W = 16,
  parameter int EN_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      status_i,
  output logic              rd_hit_o,
  output logic [N-1:0]      en_o,
  output logic [DATA_W-1:0] rdata
);
  logic          hit;
  logic          wr_hit;
  logic [N-1:0]  en_q;
  logic [N-1:0]  en_d;
  logic [DATA_W-1:0] word;
  logic          unused_wbits;

  assign hit      = (addr == REG_OFFSET);
  assign rd_hit_o = rd_en & hit;
  assign wr_hit   = wr_en & hit;

  always_comb begin
    en_d = en_q;
    if (wr_hit) en_d = wdata[EN_LSB +: N];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    word = '0;
    word[N-1:0] = status_i;
    word[EN_LSB +: N] = en_q;
    rdata = rd_hit_o ? word : '0;
  end

  assign en_o = en_q;
  assign unused_wbits = ^{wdata[DATA_W-1:EN_LSB+N], wdata[EN_LSB-1:0]};

  // R9: a write at the register offset loads the enables
  a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (en_o == $past(wdata[EN_LSB +: N])));
  // R10: without a write hit the enables hold
  a_r10_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(en_o));
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] enable;
  logic               rd_hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == SRV_REQ) begin : g_live
      assign status[i] = evt_in[i];
    end else begin : g_sticky
      irq_sticky_bit u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (evt_in[i]),
        .clr_i  (rd_hit),
        .sts_o  (status[i])
      );
    end
  end

  irq_host_port #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET),
    .N          (NUM_SRC),
    .DATA_W     (DATA_W),
    .EN_LSB     (EN_LSB)
  ) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .status_i (status),
    .rd_hit_o (rd_hit),
    .en_o     (enable),
    .rdata    (rdata)
  );

  assign irq_o = |(status & enable);

  // R8: with every source masked the interrupt stays low
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq_o);
  // R2: no read hit means the read data bus is idle
  a_r2_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == REG_OFFSET) |-> (rdata == '0));
endmodule

// File: tb/irq_ctl_reg_tb_top.sv
module irq_ctl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        rd_en, wr_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [6:0]  evt_in;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit [6:0] m_sts, m_prev, m_en;

  always #10 clk = ~clk;

  irq_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq_o(irq_o)
  );

  task automatic step(input bit [6:0] ev, input bit rd, input bit wr,
                      input bit [7:0] a, input bit [15:0] wd, input string tag);
    bit [6:0]  es;
    bit        ei;
    bit [15:0] er;
    bit        hit;
    @(negedge clk);
    evt_in = ev; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    #2;
    hit = (a == 8'h0C);
    es = m_sts; es[3] = ev[3];
    ei = |(es & m_en);
    er = (rd && hit) ? {1'b0, m_en, 1'b0, es} : 16'h0;
    checks++;
    if (irq_o !== ei) begin
      errors++;
      $display("FAIL %s irq_o actual %b expected %b", tag, irq_o, ei);
    end
    checks++;
    if (rdata !== er) begin
      errors++;
      $display("FAIL %s rdata actual %h expected %h", tag, rdata, er);
    end
    @(posedge clk);
    for (int i = 0; i < 7; i++) begin
      if (i != 3) begin
        if (ev[i] && !m_prev[i]) m_sts[i] = 1'b1;
        else if (rd && hit)      m_sts[i] = 1'b0;
      end
    end
    m_sts[3] = 1'b0;
    m_prev = ev;
    if (wr && hit) m_en = wd[14:8];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_in = '0; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
    m_sts = '0; m_prev = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(7'h00, 1, 0, 8'h0C, 16'h0, "R1");
    // R9 write all ones: only enables change
    step(7'h00, 0, 1, 8'h0C, 16'hFFFF, "R9");
    step(7'h00, 1, 0, 8'h0C, 16'h0, "R9");
    // R3 / R4 each sticky source: pulse, read set, read cleared
    for (int i = 0; i < 7; i++) begin
      if (i != 3) begin
        step(7'(1 << i), 0, 0, 8'h0C, 16'h0, "R3");
        step(7'h00, 1, 0, 8'h0C, 16'h0, "R3");
        step(7'h00, 1, 0, 8'h0C, 16'h0, "R4");
      end
    end
    // R5 level held across a clear
    step(7'h02, 0, 0, 8'h0C, 16'h0, "R5");
    step(7'h02, 1, 0, 8'h0C, 16'h0, "R5");
    step(7'h02, 1, 0, 8'h0C, 16'h0, "R5");
    step(7'h02, 0, 0, 8'h0C, 16'h0, "R5");
    step(7'h00, 0, 0, 8'h0C, 16'h0, "R5");
    step(7'h02, 0, 0, 8'h0C, 16'h0, "R5");
    step(7'h00, 1, 0, 8'h0C, 16'h0, "R5");
    // R6 rise in the same cycle as a read
    step(7'h00, 0, 0, 8'h0C, 16'h0, "R6");
    step(7'h04, 1, 0, 8'h0C, 16'h0, "R6");
    step(7'h00, 1, 0, 8'h0C, 16'h0, "R6");
    step(7'h00, 1, 0, 8'h0C, 16'h0, "R6");
    // R7 live service-request bit
    step(7'h08, 1, 0, 8'h0C, 16'h0, "R7");
    step(7'h08, 1, 0, 8'h0C, 16'h0, "R7");
    step(7'h00, 1, 0, 8'h0C, 16'h0, "R7");
    // R8 masking with only memory error enabled
    step(7'h00, 0, 1, 8'h0C, 16'h4000, "R8");
    step(7'h01, 0, 0, 8'h0C, 16'h0, "R8");
    step(7'h08, 0, 0, 8'h0C, 16'h0, "R8");
    step(7'h40, 0, 0, 8'h0C, 16'h0, "R8");
    step(7'h00, 1, 0, 8'h0C, 16'h0, "R8");
    step(7'h00, 0, 0, 8'h0C, 16'h0, "R8");
    // R10 other offsets ignored
    step(7'h00, 0, 1, 8'h08, 16'h7F00, "R10");
    step(7'h20, 0, 0, 8'h0C, 16'h0, "R10");
    step(7'h00, 1, 0, 8'h04, 16'h0, "R10");
    step(7'h00, 1, 0, 8'h0D, 16'h0, "R10");
    step(7'h00, 1, 0, 8'h0C, 16'h0, "R10");
    // R2 mixed traffic against the model
    for (int n = 0; n < 300; n++) begin
      bit [31:0] r;
      r = $urandom;
      step(r[6:0], r[7] & r[8], r[9] & r[10] & r[11],
           r[12] ? 8'h0C : 8'h08, {r[31:24], r[23:16]}, "R2");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule